// File: doc/BRIEF.md
# SRAM Parity Guard with Targeted Error Injection

This block sits between a requester and a single-port, word-wide SRAM with a read latency of one cycle, and adds parity protection. On every accepted write it computes one even-parity bit per byte lane and stores those bits in a side field next to the data. On every accepted read it recomputes parity from the returned word and compares the result with the stored side bits. A mismatch is flagged on the response.

For self-test, an injection mode can be armed that inverts all stored parity bits of any write aimed at one chosen word, so that a later read of that word must fail. The first failing read is recorded: its word-aligned byte offset is latched in an error-capture register and a one-cycle interrupt pulse is raised. Reading the capture register returns its value and empties it. Later failures are not recorded until that read happens. A small register port sets the enables and the injection target and reads the capture.

The request side is valid/ready. A request fires in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` follows the SRAM's `mem_ready`. The requester must hold its request stable while `req_ready` is low. The response has no back-pressure: `rsp_valid` is high for exactly one cycle, the cycle after a read fires, and the requester must take it then.

Top module: `sram_parity_guard`

## Requirements
- R1: After reset the control register (select 0) and the target register (select 1) read 0, the capture register (select 2) reads 0, and `irq` is low.
- R2: When parity is enabled (select 0, bit 0) and the write is not targeted, `mem_wpar[i]` on a write equals the XOR of data bits `[8i+7:8i]`, so that each lane plus its parity bit has even parity.
- R3: When parity is disabled, writes that are not targeted store `mem_wpar = 0`, and reads issued while parity is disabled never assert `rsp_perr` or capture an error.
- R4: When injection is enabled (select 0, bit 1), a write whose address bits `[19:2]` equal the target's bits `[19:2]` stores the bitwise inverse of the normal parity field. Address bits 1..0 take no part in the match. Writes to other words are unaffected.
- R5: Injection works independently of the parity enable: with parity off and injection on, a targeted write stores `mem_wpar = 4'hF`.
- R6: `rsp_valid` is high exactly in the cycle after a read fires. In that cycle `rsp_data` equals the SRAM word, and `rsp_perr` is high when parity was enabled at the request and the recomputed parity differs from the stored parity.
- R7: The first parity error loads the capture register with the read's byte offset, word-aligned and zero-extended to 32 bits, and `irq` is high for exactly the next cycle.
- R8: While the capture register holds an error and is not being read, further parity errors change neither its value nor `irq`.
- R9: A read of the capture register returns its current value and clears it to 0 at the following clock edge. Writes to select 2 have no effect.
- R10: If a parity error is flagged in the same cycle that the capture register is read, the read returns the old value, the new address is captured, and `irq` pulses.
- R11: A request fires only when `req_valid` and `req_ready` are both high, and `req_ready` equals `mem_ready`. Without a fire, `mem_en` stays low and no response follows.
- R12: Writing the target register keeps only bits `[19:2]`. It reads back with every other bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears capture when select is 2) |
| reg_sel | input | 2 | Register select: 0 control, 1 target, 2 capture |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_we | input | 1 | Request is a write |
| req_addr | input | 20 | Request byte offset |
| req_wdata | input | 32 | Request write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data |
| rsp_perr | output | 1 | Read response parity error |
| mem_ready | input | 1 | SRAM can accept an access |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | 18 | SRAM word address |
| mem_wdata | output | 32 | SRAM write data |
| mem_wpar | output | 4 | SRAM stored parity bits |
| mem_rdata | input | 32 | SRAM read data, one cycle after a read |
| mem_rpar | input | 4 | SRAM stored parity bits, one cycle after a read |
| irq | output | 1 | One-cycle pulse on error capture |

## Verification
The capture logic has two sources that can act in the same cycle: a parity error arriving from the read pipeline, and the clear-on-read of the capture register from the register port. The bench first leaves an error held. It then reads a second corrupted word and asserts the capture-register read in the same cycle the failing response appears. It judges the result by three things: the register read must return the old address, `irq` must pulse one cycle later, and a fresh read must return the new address. A further case raises an error while the capture is held and no read is pending, and expects no pulse and no change.

// File: rtl/spg_pkg.sv
package spg_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_TGT  = 2'd1,
    SEL_ERR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/spg_lane_parity.sv
module spg_lane_parity #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0]          data,
  output logic [DATA_W/LANE_W-1:0]   par
);
  localparam int LANES = DATA_W / LANE_W;

  // Even parity per lane: the bit is the XOR of the lane.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign par[i] = ^data[i*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/spg_ctrl_regs.sv
module spg_ctrl_regs
  import spg_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFS    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [1:0]         reg_sel,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic [REG_W-1:0]   err_addr,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               par_en,
  output logic               inj_en,
  output logic [ADDR_W-OFS-1:0] tgt_word,
  output logic               err_clr
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_sel);

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^{reg_wdata[REG_W-1:ADDR_W], reg_wdata[OFS-1:2], reg_wdata[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_en   <= 1'b0;
      inj_en   <= 1'b0;
      tgt_word <= '0;
    end else if (reg_wr) begin
      case (sel)
        SEL_CTRL: begin
          par_en <= reg_wdata[0];
          inj_en <= reg_wdata[1];
        end
        SEL_TGT:  tgt_word <= reg_wdata[ADDR_W-1:OFS];
        default:  ;
      endcase
    end
  end

  assign err_clr = reg_rd && (sel == SEL_ERR);

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_CTRL: reg_rdata[1:0] = {inj_en, par_en};
      SEL_TGT:  reg_rdata[ADDR_W-1:OFS] = tgt_word;
      SEL_ERR:  reg_rdata = err_addr;
      default:  reg_rdata = '0;
    endcase
  end

  // R12
  tgt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == SEL_TGT) |=> (tgt_word == $past(reg_wdata[ADDR_W-1:OFS])));
endmodule

// File: rtl/spg_err_capture.sv
module spg_err_capture
  import spg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_evt,
  input  logic [REG_W-1:0] err_addr_in,
  input  logic             err_clr,
  output logic [REG_W-1:0] err_addr,
  output logic             irq
);
  logic held;
  logic cap;

  // A clear in the same cycle frees the slot for the new error.
  assign cap = err_evt && (!held || err_clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      err_addr <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= cap;
      if (cap) begin
        held     <= 1'b1;
        err_addr <= err_addr_in;
      end else if (err_clr) begin
        held     <= 1'b0;
        err_addr <= '0;
      end
    end
  end

  // R7
  irq_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> held);
  // R7
  first_err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !held) |=> irq);
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !err_clr) |=> ($stable(err_addr) && !irq));
  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !err_evt) |=> (err_addr == '0));
endmodule

// File: rtl/sram_parity_guard.sv
module sram_parity_guard
  import spg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [1:0]                 reg_sel,
  input  logic [REG_W-1:0]           reg_wdata,
  output logic [REG_W-1:0]           reg_rdata,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_we,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_data,
  output logic                       rsp_perr,
  input  logic                       mem_ready,
  output logic                       mem_en,
  output logic                       mem_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr,
  output logic [DATA_W-1:0]          mem_wdata,
  output logic [DATA_W/LANE_W-1:0]   mem_wpar,
  input  logic [DATA_W-1:0]          mem_rdata,
  input  logic [DATA_W/LANE_W-1:0]   mem_rpar,
  output logic                       irq
);
  localparam int LANES  = DATA_W / LANE_W;
  localparam int OFS    = $clog2(DATA_W / 8);
  localparam int WORD_W = ADDR_W - OFS;

  logic                par_en, inj_en, err_clr;
  logic [WORD_W-1:0]   tgt_word, req_word;
  logic [REG_W-1:0]    err_addr, err_addr_in;
  logic [LANES-1:0]    wr_par, rd_par;
  logic                fire, inj_hit;
  logic                rd_pend, rd_chk;
  logic [WORD_W-1:0]   rd_word;

  logic unused_addr_bits;
  assign unused_addr_bits = ^req_addr[OFS-1:0];

  spg_ctrl_regs #(.ADDR_W(ADDR_W), .OFS(OFS)) i_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .err_addr(err_addr),
    .reg_rdata(reg_rdata), .par_en(par_en), .inj_en(inj_en),
    .tgt_word(tgt_word), .err_clr(err_clr)
  );

  spg_lane_parity #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_wr_par (
    .data(req_wdata), .par(wr_par)
  );

  spg_lane_parity #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_rd_par (
    .data(mem_rdata), .par(rd_par)
  );

  // Request side
  assign req_ready = mem_ready;
  assign fire      = req_valid && req_ready;
  assign req_word  = req_addr[ADDR_W-1:OFS];
  assign inj_hit   = inj_en && (req_word == tgt_word);

  assign mem_en    = fire;
  assign mem_we    = req_we;
  assign mem_addr  = req_word;
  assign mem_wdata = req_wdata;
  assign mem_wpar  = (par_en ? wr_par : '0) ^ {LANES{inj_hit}};

  // Read response pipeline, one cycle of SRAM latency
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_chk  <= 1'b0;
      rd_word <= '0;
    end else begin
      rd_pend <= fire && !req_we;
      if (fire && !req_we) begin
        rd_chk  <= par_en;
        rd_word <= req_word;
      end
    end
  end

  assign rsp_valid = rd_pend;
  assign rsp_data  = mem_rdata;
  assign rsp_perr  = rd_pend && rd_chk && (rd_par != mem_rpar);

  always_comb begin
    err_addr_in = '0;
    err_addr_in[ADDR_W-1:OFS] = rd_word;
  end

  spg_err_capture i_cap (
    .clk(clk), .rst_n(rst_n), .err_evt(rsp_perr), .err_addr_in(err_addr_in),
    .err_clr(err_clr), .err_addr(err_addr), .irq(irq)
  );

  // R11
  fire_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (req_valid && mem_ready));
  // R6
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_en && !mem_we));
  // R6
  read_gets_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> rsp_valid);
  // R3
  no_check_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(par_en)) |-> !rsp_perr);
endmodule

// File: tb/test_sram_parity_guard.sv
module test_sram_parity_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [1:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        req_valid = 0, req_ready, req_we = 0;
  logic [19:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic        rsp_valid, rsp_perr;
  logic [31:0] rsp_data;
  logic        mem_ready = 1, mem_en, mem_we;
  logic [17:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0]  mem_wpar, mem_rpar;
  logic        irq;

  int total = 0, fails = 0;

  always #5 clk = ~clk;

  sram_parity_guard i_sram_parity_guard (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_perr(rsp_perr),
    .mem_ready(mem_ready), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wpar(mem_wpar), .mem_rdata(mem_rdata),
    .mem_rpar(mem_rpar), .irq(irq)
  );

  // SRAM model: 64 words, one cycle read latency
  logic [31:0] m_data [64];
  logic [3:0]  m_par  [64];
  always_ff @(posedge clk) begin
    if (mem_en && mem_we) begin
      m_data[mem_addr[5:0]] <= mem_wdata;
      m_par[mem_addr[5:0]]  <= mem_wpar;
    end
    if (mem_en && !mem_we) begin
      mem_rdata <= m_data[mem_addr[5:0]];
      mem_rpar  <= m_par[mem_addr[5:0]];
    end
  end

  function automatic logic [3:0] par4(input logic [31:0] d);
    return {^d[31:24], ^d[23:16], ^d[15:8], ^d[7:0]};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [31:0] val);
    @(negedge clk);
    reg_rd = 1; reg_sel = sel;
    #1 val = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic mem_write(input logic [19:0] a, input logic [31:0] d,
                           input logic [3:0] exp_par, input string tag);
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = a; req_wdata = d;
    #1 check(mem_en && mem_wpar == exp_par, tag, {28'd0, mem_wpar}, {28'd0, exp_par});
    @(negedge clk);
    req_valid = 0; req_we = 0;
  endtask

  // Read a word; optionally read the capture register in the response cycle.
  task automatic mem_read(input logic [19:0] a, input logic [31:0] exp_d,
                          input logic exp_perr, input logic exp_irq,
                          input logic do_clr, input logic [31:0] exp_clr,
                          input string tag);
    logic [31:0] v;
    @(negedge clk);
    req_valid = 1; req_we = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    if (do_clr) begin reg_rd = 1; reg_sel = 2'd2; end
    #1;
    check(rsp_valid, {tag, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
    check(rsp_data == exp_d, {tag, " rsp_data"}, rsp_data, exp_d);
    check(rsp_perr == exp_perr, {tag, " rsp_perr"}, {31'd0, rsp_perr}, {31'd0, exp_perr});
    if (do_clr) begin
      v = reg_rdata;
      check(v == exp_clr, {tag, " read in same cycle"}, v, exp_clr);
    end
    @(negedge clk);
    reg_rd = 0;
    #1 check(irq == exp_irq, {tag, " irq"}, {31'd0, irq}, {31'd0, exp_irq});
    @(negedge clk);
    #1 check(!irq, {tag, " irq one cycle"}, {31'd0, irq}, 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    #1 check(!irq, "R1 irq", {31'd0, irq}, 0);
    reg_read(2'd0, v); check(v == 0, "R1 ctrl", v, 0);
    reg_read(2'd1, v); check(v == 0, "R1 target", v, 0);
    reg_read(2'd2, v); check(v == 0, "R1 capture", v, 0);
  endtask

  task automatic t_gen_check;
    reg_write(2'd0, 32'h1);
    mem_write(20'h10, 32'h12345678, par4(32'h12345678), "R2 lanes A");
    mem_write(20'h14, 32'h01FF0380, par4(32'h01FF0380), "R2 lanes B");
    mem_read(20'h10, 32'h12345678, 0, 0, 0, 0, "R6 clean A");
    mem_read(20'h14, 32'h01FF0380, 0, 0, 0, 0, "R6 clean B");
  endtask

  task automatic t_disabled;
    reg_write(2'd0, 32'h0);
    mem_write(20'h18, 32'h00000001, 4'h0, "R3 zero parity");
    mem_read(20'h18, 32'h1, 0, 0, 0, 0, "R3 no check when off");
  endtask

  task automatic t_inject;
    logic [31:0] v;
    reg_write(2'd0, 32'h3);
    reg_write(2'd1, 32'h20);
    mem_write(20'h22, 32'hA5A50F01, ~par4(32'hA5A50F01), "R4 targeted, low bits ignored");
    mem_write(20'h24, 32'hA5A50F01, par4(32'hA5A50F01), "R4 other word");
    mem_read(20'h24, 32'hA5A50F01, 0, 0, 0, 0, "R4 other word read");
    mem_read(20'h20, 32'hA5A50F01, 1, 1, 0, 0, "R7 first error");
    reg_read(2'd2, v); check(v == 32'h20, "R7 captured offset", v, 32'h20);
    reg_read(2'd2, v); check(v == 0, "R9 cleared on read", v, 0);
  endtask

  task automatic t_hold;
    logic [31:0] v;
    reg_write(2'd1, 32'h30);
    mem_write(20'h30, 32'h0000FFFE, ~par4(32'h0000FFFE), "R4 second target");
    mem_read(20'h20, 32'hA5A50F01, 1, 1, 0, 0, "R7 capture again");
    mem_read(20'h30, 32'h0000FFFE, 1, 0, 0, 0, "R8 no pulse while held");
    reg_write(2'd2, 32'h1234);
    reg_read(2'd2, v); check(v == 32'h20, "R8/R9 held value, write ignored", v, 32'h20);
  endtask

  task automatic t_same_cycle;
    logic [31:0] v;
    mem_read(20'h20, 32'hA5A50F01, 1, 1, 0, 0, "R10 setup error");
    mem_read(20'h30, 32'h0000FFFE, 1, 1, 1, 32'h20, "R10 clear with error");
    reg_read(2'd2, v); check(v == 32'h30, "R10 new address kept", v, 32'h30);
  endtask

  task automatic t_indep;
    reg_write(2'd0, 32'h2);
    reg_write(2'd1, 32'h38);
    mem_write(20'h38, 32'h76543210, 4'hF, "R5 injection with parity off");
    mem_read(20'h38, 32'h76543210, 0, 0, 0, 0, "R3 off, no error");
  endtask

  task automatic t_stall;
    @(negedge clk);
    mem_ready = 0; req_valid = 1; req_we = 0; req_addr = 20'h10;
    #1 check(!req_ready && !mem_en, "R11 stalled", {30'd0, req_ready, mem_en}, 0);
    @(negedge clk);
    req_valid = 0; mem_ready = 1;
    #1 check(!rsp_valid, "R11 no response", {31'd0, rsp_valid}, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    reg_write(2'd1, 32'hFFFFFFFF);
    reg_read(2'd1, v); check(v == 32'h000FFFFC, "R12 target bits", v, 32'h000FFFFC);
    reg_read(2'd0, v); check(v == 32'h2, "R12 control bits", v, 32'h2);
  endtask

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_gen_check();
    t_disabled();
    t_inject();
    t_hold();
    t_same_cycle();
    t_indep();
    t_stall();
    t_regmap();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule